// File: doc/BRIEF.md
# SECDED-Protected Word Memory with Fault Injection

This block is a single-port synchronous memory. With the ECC parameter set, each 72-bit location holds a 64-bit payload in bits 63:0 and an 8-bit check field in bits 71:64. The check field is computed from the payload on every write. It uses an extended Hamming code: seven position-weighted parity bits (bits 70:64) plus an overall parity bit (bit 71) that makes the whole word even.

Every read passes the stored word through a syndrome decoder. A word with one flipped bit is repaired on the output only, and the array keeps the damaged copy. A word with two flipped bits is reported and passed through unrepaired. Two write-side inputs corrupt the stored payload on purpose, so that software and test benches can drive both error paths. An optional register stage follows the decoder. A synchronous reset clears the output path. With ECC off, the memory stores 72 plain bits with per-byte write enables and the status flags stay low.

Top module: `secded_ram`

## Requirements
- R1: In ECC mode, a write with all nine byte enables high stores the payload. A later read of that word, with no injection, returns the payload on dout[63:0] with err_single and err_double both low.
- R2: A stored word with exactly one flipped bit reads back with dout[63:0] equal to the original payload, err_single high and err_double low.
- R3: A stored word with exactly two flipped bits reads back with err_double high and err_single low. dout[63:0] carries the stored payload with both flipped bits still inverted.
- R4: err_single and err_double are never high in the same cycle.
- R5: Reading a word that has a repairable fault does not rewrite the array. Reading it again reports err_single once more.
- R6: In ECC mode, a write with any byte enable low leaves the addressed location unchanged.
- R7: inj_single on a write inverts payload bit 30 in the stored word. inj_double inverts payload bits 30 and 62. When both are high on one write, only the two-bit pattern (bits 30 and 62) is applied.
- R8: A read accepted at one clock edge shows its result after that edge when OUT_REG is 0. When OUT_REG is 1, it shows after the following edge, and until then the previous result stays visible.
- R9: A clock edge with rst high sets dout, err_single and err_double to zero. It does not alter the array contents.
- R10: With ECC off, all 72 bits store plain data, byte_we[k] gates bits 8k+7:8k, the injection inputs have no effect, and both flags stay low.
- R11: While no read is accepted, dout and both flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset of the read and output registers |
| en | input | 1 | Access strobe |
| we | input | 1 | High selects a write, low selects a read, when en is high |
| byte_we | input | 9 | Per-byte write enables; must be all ones for an ECC write |
| addr | input | ADDR_W | Word address |
| din | input | 72 | Write data; ECC mode uses bits 63:0 only |
| inj_single | input | 1 | Store the write with payload bit 30 inverted |
| inj_double | input | 1 | Store the write with payload bits 30 and 62 inverted |
| dout | output | 72 | Read data; in ECC mode bits 63:0 are the repaired payload |
| err_single | output | 1 | A one-bit fault was found and repaired |
| err_double | output | 1 | A two-bit fault was found and not repaired |

## Verification
Two cases can meet on one write, and the bench provokes both. In the first, both injection inputs are raised together on every fourth address of a full sweep. Such words must read back as two-bit faults with bits 30 and 62 inverted, never as repaired one-bit faults. In the second, a write with some byte lanes disabled goes to an address that already holds an injected fault. The ECC instance must keep the old word and report the same flag as before. The plain instance beside it must merge only the enabled lanes.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DW    = 64;
    localparam int CW    = 8;
    localparam int WW    = DW + CW;
    localparam int HB    = CW - 1;
    localparam int BE_W  = WW / 8;
    localparam int INJ_A = 30;
    localparam int INJ_B = 62;

    typedef struct packed {
        logic [WW-1:0] raw;
        logic [WW-1:0] dout;
        logic          sbe;
        logic          dbe;
    } ram_state_t;

    // codeword position (1-based, powers of two skipped) of payload bit idx
    function automatic int code_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // payload bits covered by Hamming check bit j
    function automatic logic [DW-1:0] cover_mask(input int j);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++) m[i] = ((code_pos(i) >> j) & 1) != 0;
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] chk
);
    for (genvar j = 0; j < HB; j++) begin : g_hbit
        localparam logic [DW-1:0] MASK = cover_mask(j);
        assign chk[j] = ^(data & MASK);
    end
    assign chk[HB] = ^{data, chk[HB-1:0]};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [WW-1:0] word,
    output logic [WW-1:0] fixed,
    output logic          sbe,
    output logic          dbe
);
    logic [HB-1:0] syn;
    logic          odd;
    logic [WW-1:0] flip;

    for (genvar j = 0; j < HB; j++) begin : g_syn
        localparam logic [DW-1:0] MASK = cover_mask(j);
        assign syn[j] = ^(word[DW-1:0] & MASK) ^ word[DW+j];
    end

    assign odd = ^word;

    for (genvar i = 0; i < DW; i++) begin : g_dflip
        localparam int POS = code_pos(i);
        assign flip[i] = odd && (syn == HB'(POS));
    end

    for (genvar j = 0; j < HB; j++) begin : g_cflip
        assign flip[DW+j] = odd && (syn == HB'(1 << j));
    end

    assign flip[WW-1] = odd && (syn == '0);

    assign fixed = word ^ flip;
    assign sbe   = odd;
    assign dbe   = !odd && (syn != '0);
endmodule

// File: rtl/sram_core.sv
module sram_core #(
    parameter int ADDR_W = 12,
    parameter int WIDTH  = 72,
    localparam int LANES = WIDTH / 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr && lane_en[k]) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter bit ECC     = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [BE_W-1:0]   byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WW-1:0]     din,
    input  logic              inj_single,
    input  logic              inj_double,
    output logic [WW-1:0]     dout,
    output logic              err_single,
    output logic              err_double
);
    ram_state_t      st_d, st_q;
    logic            rd_go;
    logic            wr_go;
    logic [BE_W-1:0] lane_en;
    logic [WW-1:0]   wword;
    logic [WW-1:0]   rd_word;
    logic [WW-1:0]   dec_word;
    logic            dec_sbe;
    logic            dec_dbe;

    assign rd_go = en && !we;

    if (ECC) begin : g_ecc
        logic [DW-1:0] inj_mask;
        logic [CW-1:0] chk;

        always_comb begin
            inj_mask = '0;
            if (inj_double) begin
                inj_mask[INJ_A] = 1'b1;
                inj_mask[INJ_B] = 1'b1;
            end else if (inj_single) begin
                inj_mask[INJ_A] = 1'b1;
            end
        end

        secded_enc u_enc (
            .data (din[DW-1:0]),
            .chk  (chk)
        );

        secded_dec u_dec (
            .word  (st_q.raw),
            .fixed (dec_word),
            .sbe   (dec_sbe),
            .dbe   (dec_dbe)
        );

        assign wr_go   = en && we && (&byte_we);
        assign lane_en = '1;
        assign wword   = {chk, din[DW-1:0] ^ inj_mask};
    end else begin : g_plain
        assign wr_go    = en && we;
        assign lane_en  = byte_we;
        assign wword    = din;
        assign dec_word = st_q.raw;
        assign dec_sbe  = 1'b0;
        assign dec_dbe  = 1'b0;
    end

    sram_core #(
        .ADDR_W (ADDR_W),
        .WIDTH  (WW)
    ) u_core (
        .clk     (clk),
        .wr      (wr_go),
        .lane_en (lane_en),
        .addr    (addr),
        .wdata   (wword),
        .rdata   (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (rd_go) st_d.raw = rd_word;
        st_d.dout = dec_word;
        st_d.sbe  = dec_sbe;
        st_d.dbe  = dec_dbe;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    if (OUT_REG) begin : g_oreg
        assign dout       = st_q.dout;
        assign err_single = st_q.sbe;
        assign err_double = st_q.dbe;
    end else begin : g_ocomb
        assign dout       = dec_word;
        assign err_single = dec_sbe;
        assign err_double = dec_dbe;
    end
endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
    parameter bit ECC_ON = 1'b1,
    parameter int W      = 72,
    parameter int BW     = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          we,
    input logic [BW-1:0] byte_we,
    input logic [W-1:0]  dout,
    input logic          err_single,
    input logic          err_double,
    input logic          wr_go
);
    logic quiet_q;

    always_ff @(posedge clk) begin
        if (rst) quiet_q <= 1'b0;
        else     quiet_q <= !(en && !we);
    end

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(err_single && err_double));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0) && !err_single && !err_double);

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (quiet_q && !(en && !we)) |=> ($stable(dout) && $stable(err_single) && $stable(err_double)));

    if (ECC_ON) begin : g_ecc_props
        a_r6_partial_write_blocked: assert property (@(posedge clk) disable iff (rst)
            (en && we && (byte_we != '1)) |-> !wr_go);
    end else begin : g_plain_props
        a_r10_flags_low: assert property (@(posedge clk) disable iff (rst)
            !err_single && !err_double);
    end
endmodule

bind secded_ram secded_ram_chk #(
    .ECC_ON (ECC),
    .W      (secded_pkg::WW),
    .BW     (secded_pkg::BE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .we         (we),
    .byte_we    (byte_we),
    .dout       (dout),
    .err_single (err_single),
    .err_double (err_double),
    .wr_go      (wr_go)
);

// File: tb/sim_secded_ram.sv
`timescale 1ns/1ps
module sim_secded_ram;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0, we = 1'b0;
    logic [8:0]    byte_we = '0;
    logic [AW-1:0] addr = '0;
    logic [71:0]   din = '0;
    logic          inj_s = 1'b0, inj_d = 1'b0;
    logic [71:0]   dout0, dout1;
    logic          s0, d0, s1, d1;

    int total = 0;
    int bad = 0;

    logic [63:0] m0_data [N];
    int          m0_kind [N];
    logic [71:0] m1_word [N];
    logic [71:0] r0_d, r1_d;
    logic [1:0]  r0_f, r1_f;

    always #10 clk = ~clk;

    secded_ram #(.ADDR_W(AW), .ECC(1'b1), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .en(en), .we(we), .byte_we(byte_we), .addr(addr),
        .din(din), .inj_single(inj_s), .inj_double(inj_d),
        .dout(dout0), .err_single(s0), .err_double(d0));

    secded_ram #(.ADDR_W(AW), .ECC(1'b0), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst(rst), .en(en), .we(we), .byte_we(byte_we), .addr(addr),
        .din(din), .inj_single(inj_s), .inj_double(inj_d),
        .dout(dout1), .err_single(s1), .err_double(d1));

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] pat(input int a, input int salt);
        logic [63:0] lo;
        logic [7:0]  hi;
        lo = 64'h0F1E2D3C4B5A6978 ^ (64'(a + salt) * 64'h9E3779B97F4A7C15);
        hi = 8'((a + salt) * 29 + 7);
        return {hi, lo};
    endfunction

    function automatic logic [63:0] exp0_data(input int a);
        logic [63:0] v;
        v = m0_data[a];
        if (m0_kind[a] == 2) begin
            v[30] = ~v[30];
            v[62] = ~v[62];
        end
        return v;
    endfunction

    function automatic logic [1:0] exp0_flags(input int a);
        return (m0_kind[a] == 1) ? 2'b10 : (m0_kind[a] == 2) ? 2'b01 : 2'b00;
    endfunction

    task automatic do_write(input int a, input logic [71:0] d, input logic [8:0] be,
                            input logic is, input logic id);
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = AW'(a); din = d; byte_we = be;
        inj_s = is; inj_d = id;
        @(negedge clk);
        en = 1'b0; we = 1'b0; inj_s = 1'b0; inj_d = 1'b0; byte_we = '0;
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = AW'(a);
        @(negedge clk);
        en = 1'b0;
        r1_d = dout1; r1_f = {s1, d1};
        @(negedge clk);
        r0_d = dout0; r0_f = {s0, d0};
    endtask

    task automatic check_addr(input int a, input string tag);
        check({tag, " u0 data"}, {8'h0, r0_d[63:0]}, {8'h0, exp0_data(a)});
        check({tag, " u0 flags"}, {70'h0, r0_f}, {70'h0, exp0_flags(a)});
        check({tag, " R10 u1 word"}, r1_d, m1_word[a]);
        check({tag, " R10 u1 flags"}, {70'h0, r1_f}, 72'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 reset u0 dout", dout0, 72'h0);
        check("R9 reset u0 flags", {70'h0, s0, d0}, 72'h0);
        check("R9 reset u1 dout", dout1, 72'h0);

        // R1 R2 R3 R7 R10: sweep with all injection modes (mode 3 = both requests)
        for (int a = 0; a < N; a++) begin
            logic [71:0] d;
            int mode;
            d = pat(a, 0);
            mode = a % 4;
            do_write(a, d, 9'h1FF, (mode == 1) || (mode == 3), mode >= 2);
            m0_data[a] = d[63:0];
            m0_kind[a] = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
            m1_word[a] = d;
        end
        for (int a = 0; a < N; a++) begin
            do_read(a);
            case (a % 4)
                0: check_addr(a, "R1 clean");
                1: check_addr(a, "R2 R7 single");
                2: check_addr(a, "R3 R7 double");
                default: check_addr(a, "R7 both-inject");
            endcase
        end

        // R5: repeated read of a repaired word still reports it
        do_read(1);
        check_addr(1, "R5 reread1");
        do_read(1);
        check_addr(1, "R5 reread2");

        // R6 R10: partial byte enables
        for (int a = 0; a < N; a++) begin
            logic [71:0] d;
            logic [8:0]  be;
            logic [71:0] lm;
            d = pat(a, 100);
            be = 9'h1FF ^ (9'h1 << (a % 9));
            lm = '0;
            for (int k = 0; k < 9; k++) if (be[k]) lm[8*k +: 8] = 8'hFF;
            do_write(a, d, be, a[0], a[1]);
            m1_word[a] = (m1_word[a] & ~lm) | (d & lm);
        end
        for (int a = 0; a < N; a++) begin
            do_read(a);
            check_addr(a, "R6 partial");
        end

        // R11: outputs hold while idle
        do_read(2);
        repeat (4) @(negedge clk);
        check("R11 hold u0 data", {8'h0, dout0[63:0]}, {8'h0, exp0_data(2)});
        check("R11 hold u0 flags", {70'h0, s0, d0}, {70'h0, exp0_flags(2)});
        check("R11 hold u1 word", dout1, m1_word[2]);

        // R8: latency, read addr 0 then addr 2 back to back
        do_read(0);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = AW'(2);
        @(negedge clk);
        en = 1'b0;
        check("R8 u0 still old", {8'h0, dout0[63:0]}, {8'h0, exp0_data(0)});
        check("R8 u0 old flags", {70'h0, s0, d0}, 72'h0);
        check("R8 u1 new now", dout1, m1_word[2]);
        @(negedge clk);
        check("R8 u0 new data", {8'h0, dout0[63:0]}, {8'h0, exp0_data(2)});
        check("R8 u0 new flags", {70'h0, s0, d0}, {70'h0, exp0_flags(2)});

        // R9: mid-run reset clears outputs, keeps array
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 rst u0 dout", dout0, 72'h0);
        check("R9 rst u0 flags", {70'h0, s0, d0}, 72'h0);
        check("R9 rst u1 dout", dout1, 72'h0);
        do_read(1);
        check_addr(1, "R9 array kept");
        do_read(3);
        check_addr(3, "R9 array kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule